// File: doc/BRIEF.md
# Staged-Entry Translation Buffer

A small, fully associative translation buffer that maps virtual page numbers to physical pages. Each entry carries an address space number (ASN), a global flag, read and write permission nibbles and fault-on-read / fault-on-write flags. A lookup hits either on a matching page and ASN, or on a matching page held by a global entry that is shared by every address space.

Software fills an entry in two steps. It first writes the entry's data to a staging register, which can be read back. It then writes the virtual address to the tag select, and that write installs a new entry. The entry is built from the staged fields plus the ASN register as it stands at that moment. The slot it lands in is picked by a round-robin victim pointer.

There are three invalidation commands. One clears every entry. One clears only the non-global entries. One clears entries that match a single address under the current ASN.

Top module: `staged_xlate_buf`

## Requirements
- R1: After synchronous reset, every entry is invalid, the victim pointer is 0, the staged fields and the ASN register are zero, `ins_err` is 0 and `staged_rd` reads 0.
- R2: A write with select code 2 loads the ASN register from `wr_data[63:57]` and discards every other bit of the word.
- R3: A write with select code 0 stages an entry. The fields are taken from: fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4, granularity hint at bits 6:5, read enables at 11:8, write enables at 15:12, physical page at 58:32. `staged_rd` returns the same fields at the same positions, without the hint. It ORs the ASN register into bits 63:57, so ASN bits 0 and 1 overlap page bits 25 and 26. All other bits read 0.
- R4: A write with select code 1, while the staged hint is zero, fills the slot at the victim pointer. The entry is valid and takes its page from `wr_data[PG_SHIFT +: VPN_W]`, its other fields from the staged entry and its ASN from the current ASN register. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R5: A select code 1 write while the staged hint is nonzero changes no entry and leaves the pointer unmoved. `ins_err` is 1 for exactly the next cycle.
- R6: A write with select code 3 invalidates every entry.
- R7: A write with select code 4 invalidates every entry whose global flag is clear and keeps the global entries.
- R8: A write with select code 5 invalidates each valid entry whose page equals `wr_data[PG_SHIFT +: VPN_W]` and that is either global or tagged with the current ASN register.
- R9: A lookup hits when a valid entry has page `lk_vpn` and either has ASN `lk_asn` or is global. If several entries hit, the lowest-numbered one supplies page, permissions and fault flags. On a miss those outputs are all zero. The lookup is combinational from the stored state.
- R10: Select codes 6 and 7, and any cycle with `wr_en` low, change neither the entries, the staging register, the ASN register nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 64 | Register write data |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | 7 | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Physical page of the hit |
| lk_rperm | output | 4 | Read enables of the hit |
| lk_wperm | output | 4 | Write enables of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| staged_rd | output | 64 | Readback of the staged entry with the ASN |
| ins_err | output | 1 | One-cycle pulse after a rejected insert |

## Verification
The bench builds the buffer with ENTRIES=4 and keeps the default 30-bit page and 13-bit page shift. With only four slots, a handful of inserts wraps the victim pointer and overwrites an older entry. The same small size lets two valid entries hold one page at once, which exercises the lowest-index-wins choice on a lookup. The full 64-bit write word stays in use, so the readback overlap between the ASN and the top page bits is observed.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int PPN_W   = 27;
    localparam int ASN_W   = 7;
    localparam int PERM_W  = 4;
    localparam int GH_W    = 2;

    localparam int FR_BIT  = 1;
    localparam int FW_BIT  = 2;
    localparam int GBL_BIT = 4;
    localparam int GH_LSB  = 5;
    localparam int RE_LSB  = 8;
    localparam int WE_LSB  = 12;
    localparam int PPN_LSB = 32;
    localparam int ASN_LSB = 57;

    typedef enum logic [2:0] {
        SEL_STAGE      = 3'd0,
        SEL_TAG        = 3'd1,
        SEL_ASN        = 3'd2,
        SEL_FLUSH_ALL  = 3'd3,
        SEL_FLUSH_PRIV = 3'd4,
        SEL_FLUSH_ONE  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] rperm;
        logic [PERM_W-1:0] wperm;
        logic              fault_rd;
        logic              fault_wr;
        logic              gbl;
        logic [GH_W-1:0]   gh;
    } stage_t;

    typedef struct packed {
        logic [ASN_W-1:0]  asn;
        logic              gbl;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] rperm;
        logic [PERM_W-1:0] wperm;
        logic              fault_rd;
        logic              fault_wr;
    } xlat_t;

    function automatic stage_t unpack_stage(input logic [63:0] d);
        stage_t s;
        s.ppn      = d[PPN_LSB +: PPN_W];
        s.rperm    = d[RE_LSB +: PERM_W];
        s.wperm    = d[WE_LSB +: PERM_W];
        s.fault_rd = d[FR_BIT];
        s.fault_wr = d[FW_BIT];
        s.gbl      = d[GBL_BIT];
        s.gh       = d[GH_LSB +: GH_W];
        return s;
    endfunction

    function automatic logic [63:0] pack_stage(input stage_t s, input logic [ASN_W-1:0] asn);
        logic [63:0] r;
        r = '0;
        r[PPN_LSB +: PPN_W]  = s.ppn;
        r[RE_LSB +: PERM_W]  = s.rperm;
        r[WE_LSB +: PERM_W]  = s.wperm;
        r[FR_BIT]            = s.fault_rd;
        r[FW_BIT]            = s.fault_wr;
        r[GBL_BIT]           = s.gbl;
        r[ASN_LSB +: ASN_W]  = r[ASN_LSB +: ASN_W] | asn;
        return r;
    endfunction

endpackage

// File: rtl/stb_stage_regs.sv
module stb_stage_regs
    import stb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [63:0]          wr_data,
    output stage_t               stage_q,
    output logic [ASN_W-1:0]     asn_q,
    output logic [63:0]          staged_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            asn_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_STAGE)
                stage_q <= unpack_stage(wr_data);
            if (wr_sel == SEL_ASN)
                asn_q <= wr_data[ASN_LSB +: ASN_W];
        end
    end

    assign staged_rd = pack_stage(stage_q, asn_q);

    // ASN register loads only the top seven bits of the word
    assert_asn_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_ASN) |=> (asn_q == $past(wr_data[63:57])));

    // Permission nibbles read back where they were written
    assert_stage_perm_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_STAGE) |=> (staged_rd[15:8] == $past(wr_data[15:8])));

    // Unused select codes and idle cycles leave the ASN register alone
    assert_asn_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_sel > 3'd5) |=> $stable(asn_q));

endmodule

// File: rtl/stb_entry_array.sv
module stb_entry_array
    import stb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  stage_t               stage_q,
    input  logic [ASN_W-1:0]     asn_q,
    output logic [ENTRIES-1:0]   valid_vec,
    output logic [VPN_W-1:0]     vpn_arr [ENTRIES],
    output xlat_t                pay_arr [ENTRIES],
    output logic                 ins_err
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0]   ptr_q;
    logic               tag_wr;
    logic               ins_ok;
    logic               ins_bad;
    logic               do_fa;
    logic               do_fp;
    logic               do_fo;
    logic [ENTRIES-1:0] gbl_vec;
    xlat_t              new_pay;

    assign tag_wr  = wr_en && (wr_sel == SEL_TAG);
    assign ins_ok  = tag_wr && (stage_q.gh == '0);
    assign ins_bad = tag_wr && (stage_q.gh != '0);
    assign do_fa   = wr_en && (wr_sel == SEL_FLUSH_ALL);
    assign do_fp   = wr_en && (wr_sel == SEL_FLUSH_PRIV);
    assign do_fo   = wr_en && (wr_sel == SEL_FLUSH_ONE);

    always_comb begin
        new_pay.asn      = asn_q;
        new_pay.gbl      = stage_q.gbl;
        new_pay.ppn      = stage_q.ppn;
        new_pay.rperm    = stage_q.rperm;
        new_pay.wperm    = stage_q.wperm;
        new_pay.fault_rd = stage_q.fault_rd;
        new_pay.fault_wr = stage_q.fault_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            ins_err <= 1'b0;
        end else begin
            ins_err <= ins_bad;
            if (ins_ok)
                ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic             e_valid;
        logic [VPN_W-1:0] e_vpn;
        xlat_t            e_pay;
        logic             e_sel;
        logic             e_one_hit;

        assign e_sel     = ins_ok && (ptr_q == PTR_W'(i));
        assign e_one_hit = (e_vpn == wr_vpn) && (e_pay.gbl || (e_pay.asn == asn_q));

        always_ff @(posedge clk) begin
            if (rst) begin
                e_valid <= 1'b0;
                e_vpn   <= '0;
                e_pay   <= '0;
            end else if (e_sel) begin
                e_valid <= 1'b1;
                e_vpn   <= wr_vpn;
                e_pay   <= new_pay;
            end else if (do_fa) begin
                e_valid <= 1'b0;
            end else if (do_fp && !e_pay.gbl) begin
                e_valid <= 1'b0;
            end else if (do_fo && e_one_hit) begin
                e_valid <= 1'b0;
            end
        end

        assign valid_vec[i] = e_valid;
        assign gbl_vec[i]   = e_pay.gbl;
        assign vpn_arr[i]   = e_vpn;
        assign pay_arr[i]   = e_pay;
    end

    // Accepted insert makes the victim slot valid and moves the pointer
    assert_insert_fill_R4: assert property (@(posedge clk) disable iff (rst)
        ins_ok |=> (valid_vec[$past(ptr_q)] && (ENTRIES == 1 || ptr_q != $past(ptr_q))));

    // Rejected insert: pointer holds, error pulses next cycle
    assert_reject_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ins_bad |=> (ins_err && $stable(ptr_q) && $stable(valid_vec)));

    // Flush-all leaves nothing valid
    assert_flush_all_R6: assert property (@(posedge clk) disable iff (rst)
        do_fa |=> (valid_vec == '0));

    // Flush of non-global entries leaves only global ones valid
    assert_flush_priv_R7: assert property (@(posedge clk) disable iff (rst)
        do_fp |=> ((valid_vec & ~gbl_vec) == '0));

    // Single flush never sets a valid bit
    assert_flush_one_R8: assert property (@(posedge clk) disable iff (rst)
        do_fo |=> ((valid_vec & ~$past(valid_vec)) == '0));

    // Idle cycles change neither pointer nor valid bits
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_sel > 3'd5) |=> ($stable(valid_vec) && $stable(ptr_q)));

endmodule

// File: rtl/stb_lookup.sv
module stb_lookup
    import stb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30
) (
    input  logic [ENTRIES-1:0]   valid_vec,
    input  logic [VPN_W-1:0]     vpn_arr [ENTRIES],
    input  xlat_t                pay_arr [ENTRIES],
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ASN_W-1:0]     lk_asn,
    output logic                 hit,
    output xlat_t                pick
);

    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid_vec[i] && (vpn_arr[i] == lk_vpn) &&
                          (pay_arr[i].gbl || (pay_arr[i].asn == lk_asn));
    end

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                pick = pay_arr[i];
            end
        end
    end

endmodule

// File: rtl/staged_xlate_buf.sv
module staged_xlate_buf
    import stb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int VPN_W    = 30,
    parameter int PG_SHIFT = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [63:0]          wr_data,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [6:0]           lk_asn,
    output logic                 lk_hit,
    output logic [26:0]          lk_ppn,
    output logic [3:0]           lk_rperm,
    output logic [3:0]           lk_wperm,
    output logic                 lk_fault_rd,
    output logic                 lk_fault_wr,
    output logic [63:0]          staged_rd,
    output logic                 ins_err
);

    stage_t             stage_q;
    logic [ASN_W-1:0]   asn_q;
    logic [VPN_W-1:0]   wr_vpn;
    logic [ENTRIES-1:0] valid_vec;
    logic [VPN_W-1:0]   vpn_arr [ENTRIES];
    xlat_t              pay_arr [ENTRIES];
    xlat_t              pick;

    assign wr_vpn = wr_data[PG_SHIFT +: VPN_W];

    stb_stage_regs u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .stage_q   (stage_q),
        .asn_q     (asn_q),
        .staged_rd (staged_rd)
    );

    stb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_vpn    (wr_vpn),
        .stage_q   (stage_q),
        .asn_q     (asn_q),
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .pay_arr   (pay_arr),
        .ins_err   (ins_err)
    );

    stb_lookup #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) u_lookup (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .pay_arr   (pay_arr),
        .lk_vpn    (lk_vpn),
        .lk_asn    (lk_asn),
        .hit       (lk_hit),
        .pick      (pick)
    );

    assign lk_ppn      = pick.ppn;
    assign lk_rperm    = pick.rperm;
    assign lk_wperm    = pick.wperm;
    assign lk_fault_rd = pick.fault_rd;
    assign lk_fault_wr = pick.fault_wr;

    // A miss drives every translation field to zero
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_ppn == '0 && lk_rperm == '0 && lk_wperm == '0 &&
                     !lk_fault_rd && !lk_fault_wr));

endmodule

// File: tb/sim_staged_xlate_buf.sv
`timescale 1ns/1ps
module sim_staged_xlate_buf;

    localparam int ENT = 4;
    localparam int VW  = 30;
    localparam int PS  = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [63:0]   wr_data = '0;
    logic [VW-1:0] lk_vpn = '0;
    logic [6:0]    lk_asn = '0;
    logic          lk_hit;
    logic [26:0]   lk_ppn;
    logic [3:0]    lk_rperm;
    logic [3:0]    lk_wperm;
    logic          lk_fault_rd;
    logic          lk_fault_wr;
    logic [63:0]   staged_rd;
    logic          ins_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit live  = 0;

    always #2 clk = ~clk;

    staged_xlate_buf #(.ENTRIES(ENT), .VPN_W(VW), .PG_SHIFT(PS)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_rperm(lk_rperm), .lk_wperm(lk_wperm), .lk_fault_rd(lk_fault_rd),
        .lk_fault_wr(lk_fault_wr), .staged_rd(staged_rd), .ins_err(ins_err)
    );

    // Behavioural reference model
    bit          m_v   [ENT];
    logic [VW-1:0] m_vpn [ENT];
    logic [6:0]  m_asn [ENT];
    bit          m_g   [ENT];
    logic [26:0] m_ppn [ENT];
    logic [3:0]  m_re  [ENT];
    logic [3:0]  m_we  [ENT];
    bit          m_fr  [ENT];
    bit          m_fw  [ENT];
    int          m_ptr;
    logic [63:0] m_stage;
    logic [6:0]  m_asnreg;
    bit          m_err;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit e;
        logic [VW-1:0] v;
        e = 0;
        if (rst) begin
            for (int i = 0; i < ENT; i++) m_v[i] = 0;
            m_ptr = 0; m_stage = '0; m_asnreg = '0;
        end else if (wr_en) begin
            v = wr_data[PS +: VW];
            case (wr_sel)
                3'd0: m_stage = wr_data;
                3'd1: begin
                    if (m_stage[6:5] != 0) e = 1;
                    else begin
                        m_v[m_ptr]   = 1;
                        m_vpn[m_ptr] = v;
                        m_asn[m_ptr] = m_asnreg;
                        m_g[m_ptr]   = m_stage[4];
                        m_ppn[m_ptr] = m_stage[58:32];
                        m_re[m_ptr]  = m_stage[11:8];
                        m_we[m_ptr]  = m_stage[15:12];
                        m_fr[m_ptr]  = m_stage[1];
                        m_fw[m_ptr]  = m_stage[2];
                        m_ptr = (m_ptr + 1) % ENT;
                    end
                end
                3'd2: m_asnreg = wr_data[63:57];
                3'd3: for (int i = 0; i < ENT; i++) m_v[i] = 0;
                3'd4: for (int i = 0; i < ENT; i++) if (!m_g[i]) m_v[i] = 0;
                3'd5: for (int i = 0; i < ENT; i++)
                          if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asn[i] == m_asnreg))
                              m_v[i] = 0;
                default: ;
            endcase
        end
        m_err = e;
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        logic [63:0] rb;
        logic [63:0] exp_lk;
        bit h;
        if (live && !rst && !done) begin
            h = 0; exp_lk = '0;
            for (int i = ENT - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == lk_vpn && (m_g[i] || m_asn[i] == lk_asn)) begin
                    h = 1;
                    exp_lk = {25'd0, m_ppn[i], m_re[i], m_we[i], m_fr[i], m_fw[i]};
                end
            chk("R9 lookup hit", {63'd0, lk_hit}, {63'd0, h});
            chk("R9 lookup fields", {25'd0, lk_ppn, lk_rperm, lk_wperm, lk_fault_rd, lk_fault_wr}, exp_lk);
            rb = m_stage & 64'h07FF_FFFF_0000_FF16;
            rb[63:57] = rb[63:57] | m_asnreg;
            chk("R3 staged readback", staged_rd, rb);
            chk("R5 insert error pulse", {63'd0, ins_err}, {63'd0, m_err});
        end
    end

    function automatic logic [63:0] mk_stage(input logic [26:0] ppn, input logic [3:0] re,
                                             input logic [3:0] we, input bit fr, input bit fw,
                                             input bit g, input logic [1:0] gh);
        logic [63:0] r;
        r = '0;
        r[58:32] = ppn; r[11:8] = re; r[15:12] = we;
        r[1] = fr; r[2] = fw; r[4] = g; r[6:5] = gh;
        return r;
    endfunction

    function automatic logic [63:0] va(input logic [VW-1:0] vpn);
        return (64'(vpn) << PS) | 64'h0000_0000_0000_1ABC;
    endfunction

    task automatic wr(input logic [2:0] s, input logic [63:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [6:0] a, input bit eh,
                        input logic [26:0] ep, input string tag);
        @(posedge clk); #1;
        lk_vpn = v; lk_asn = a;
        @(negedge clk);
        chk(tag, {63'd0, lk_hit}, {63'd0, eh});
        if (eh) chk(tag, {37'd0, lk_ppn}, {37'd0, ep});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        live = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 no hit after reset", {63'd0, lk_hit}, 64'd0);
        chk("R1 readback zero", staged_rd, 64'd0);
        chk("R1 no error", {63'd0, ins_err}, 64'd0);

        // R2: ASN register keeps the top seven bits only
        wr(3'd2, (64'd5 << 57) | 64'h01FF_FFFF_FFFF_FFFF);
        @(negedge clk);
        chk("R2 asn readback", staged_rd, 64'd5 << 57);

        // R3: staging and readback
        wr(3'd0, mk_stage(27'h123, 4'h3, 4'h1, 1, 0, 0, 2'd0) | 64'h0000_0000_FFFF_0089);
        @(negedge clk);
        chk("R3 staged fields", staged_rd, mk_stage(27'h123, 4'h3, 4'h1, 1, 0, 0, 2'd0) | (64'd5 << 57));

        // R4: first insert lands in slot 0
        wr(3'd1, va(30'h10));
        look(30'h10, 7'd5, 1, 27'h123, "R4 inserted entry hits");
        look(30'h10, 7'd6, 0, 27'h0,   "R9 other asn misses");

        // global entry
        wr(3'd0, mk_stage(27'h456, 4'hF, 4'h0, 0, 1, 1, 2'd0));
        wr(3'd1, va(30'h20));
        look(30'h20, 7'd9, 1, 27'h456, "R9 global hits any asn");

        // R5: nonzero hint rejects the insert
        wr(3'd0, mk_stage(27'h777, 4'h1, 4'h1, 0, 0, 0, 2'd1));
        wr(3'd1, va(30'h30));
        look(30'h30, 7'd5, 0, 27'h0, "R5 rejected insert absent");

        // fill to wrap: slots 2, 3 then 0 again
        wr(3'd0, mk_stage(27'h030, 4'h1, 4'h2, 0, 0, 0, 2'd0));
        wr(3'd1, va(30'h30));
        wr(3'd0, mk_stage(27'h040, 4'h2, 4'h3, 0, 0, 0, 2'd0));
        wr(3'd1, va(30'h40));
        wr(3'd0, mk_stage(27'h050, 4'h4, 4'h5, 1, 1, 0, 2'd0));
        wr(3'd1, va(30'h50));
        look(30'h10, 7'd5, 0, 27'h0,   "R4 wrap overwrote slot 0");
        look(30'h50, 7'd5, 1, 27'h050, "R4 wrap entry hits");

        // duplicate page into slot 1: lowest index wins
        wr(3'd0, mk_stage(27'h4AA, 4'h6, 4'h7, 0, 0, 0, 2'd0));
        wr(3'd1, va(30'h40));
        look(30'h40, 7'd5, 1, 27'h4AA, "R9 lowest index wins");
        look(30'h20, 7'd9, 0, 27'h0,   "R4 global slot replaced");

        // R10: unused select codes change nothing
        wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(3'd7, 64'h0);
        look(30'h50, 7'd5, 1, 27'h050, "R10 entries kept");
        @(negedge clk);
        chk("R10 staging kept", staged_rd, mk_stage(27'h4AA, 4'h6, 4'h7, 0, 0, 0, 2'd0) | (64'd5 << 57));

        // R8: single flush under a different ASN leaves the entry
        wr(3'd2, 64'd7 << 57);
        wr(3'd5, va(30'h30));
        look(30'h30, 7'd5, 1, 27'h030, "R8 other asn not flushed");
        wr(3'd2, 64'd5 << 57);
        wr(3'd5, va(30'h40));
        look(30'h40, 7'd5, 0, 27'h0,   "R8 both duplicates flushed");
        look(30'h50, 7'd5, 1, 27'h050, "R8 unrelated entry kept");

        // R7: flush non-global keeps global
        wr(3'd0, mk_stage(27'h066, 4'h1, 4'h1, 0, 0, 1, 2'd0));
        wr(3'd1, va(30'h60));
        wr(3'd4, 64'h0);
        look(30'h60, 7'd1, 1, 27'h066, "R7 global survives");
        look(30'h50, 7'd5, 0, 27'h0,   "R7 private flushed");

        // R6: flush all
        wr(3'd3, 64'h0);
        look(30'h60, 7'd1, 0, 27'h0, "R6 all flushed");

        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule